// File: doc/BRIEF.md
# Time-Division Multiplexed Serial Link

This block carries several byte-wide peripheral streams over one serial line pair: one line out and one line in, each with its own frame-sync marker. Each direction divides time into frames. A frame holds a sync bit time followed by a fixed number of byte slots. A programmable table tells each slot which peripheral it belongs to. A peripheral that needs more bandwidth is given more slots in the table.

The transmit path works on its own, as does the receive path. On transmit, the block takes a byte from the queue of the peripheral that owns the next slot and shifts it out most significant bit first. When that queue is empty, it sends an idle byte instead and records the gap in a per-slot mask. On receive, the block waits for a sync marker and collects bits into bytes. Each finished byte is presented with the peripheral address of its slot, so an internal bus can route it.

The transmitter runs two states. TX_SYNC is one bit time with the sync line high, and it always moves to TX_DATA. TX_DATA shifts the data bits and returns to TX_SYNC after the last bit of the last slot. The receiver also runs two states. RX_HUNT ignores the data line and moves to RX_DATA when sync is seen. RX_DATA assembles bytes and returns to RX_HUNT after the last bit of the last slot. If sync arrives while in RX_DATA, it restarts at slot 0 and stays in RX_DATA.

Top module: `tdm_link`

## Requirements
- R1: `tx_fs` is high for exactly one clock every 65 clocks. The 64 clocks after each pulse carry 8 slots of 8 bits each, slot 0 first. During reset `tx_fs` is high and `tx_sd` is low.
- R2: Bytes are sent and received most significant bit first. A received byte equals the 8 bits that followed its slot start, in arrival order.
- R3: Slot k carries the next byte of the peripheral whose 3-bit address is in map entry k. Each slot consumes at most one byte: `tx_q_pop` has at most one bit set, and that bit is the owning peripheral's bit. Several slots may name the same peripheral.
- R4: When the owning peripheral's `tx_q_valid` bit is low, the slot carries 0x00 and bit k of `tx_slot_mask` reads 0. When a byte is sent, bit k reads 1. Bit k belongs to slot k of the current frame and is updated as that slot begins.
- R5: One clock after the last bit of a slot is sampled, `rx_valid` pulses for one clock. It comes with the assembled byte on `rx_byte` and the slot's map entry on `rx_addr`.
- R6: After reset, map entry k holds address k.
- R7: A map write, made through `map_wr_en` with `map_wr_slot` and `map_wr_addr`, takes effect at a frame start. Both paths take their copy of the map only when a sync marker begins a frame. A write made during a frame changes nothing until the next frame.
- R8: While the receiver is waiting for sync, data bits produce no output.
- R9: When `rx_fs` is sampled high in the middle of a frame, `rx_frame_err` pulses for one clock. The next bit is then taken as bit 7 of slot 0.
- R10: When `rx_fs` follows a frame that has finished, no framing error is reported. A loopback of `tx_sd` and `tx_fs` never reports one.
- R11: Transmit timing does not depend on what arrives at the receive inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_wr_en | input | 1 | Write strobe for the slot map |
| map_wr_slot | input | 3 | Slot whose map entry is written |
| map_wr_addr | input | 3 | Peripheral address stored for that slot |
| tx_q_valid | input | 8 | Per-peripheral flag: queue head holds a byte |
| tx_q_data | input | 64 | Per-peripheral head byte, peripheral p at bits 8p+7..8p |
| tx_q_pop | output | 8 | Per-peripheral dequeue strobe |
| tx_sd | output | 1 | Serial data out |
| tx_fs | output | 1 | Transmit frame sync |
| tx_slot_mask | output | 8 | Per-slot flag: slot holds real data |
| rx_sd | input | 1 | Serial data in |
| rx_fs | input | 1 | Receive frame sync |
| rx_byte | output | 8 | Received byte |
| rx_addr | output | 3 | Destination peripheral address for `rx_byte` |
| rx_valid | output | 1 | One-clock strobe for `rx_byte` and `rx_addr` |
| rx_frame_err | output | 1 | One-clock strobe: sync arrived inside a frame |

## Verification
Two situations are hard to reach from the ports. The first is a map write that lands inside a frame. The second is a sync marker that arrives before a frame has finished. The bench reaches the first by timing its map writes a few bit times after an observed transmit sync. It then checks, byte by byte, that the rest of that frame still follows the old table. For the second, the bench stops the loopback and drives the receive pins itself. It sends a sync marker after only three bytes, and it rewrites one map entry in the middle of a received frame. Queue depths are chosen to run out partway through a frame, so data slots and idle slots mix within single frames.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic {TX_SYNC, TX_DATA} tx_state_t;
    typedef enum logic {RX_HUNT, RX_DATA} rx_state_t;
endpackage

// File: rtl/tdm_slot_map.sv
module tdm_slot_map #(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(SLOTS)-1:0]     wr_slot,
    input  logic [ADDR_W-1:0]            wr_addr,
    output logic [SLOTS*ADDR_W-1:0]      map_flat
);
    localparam int SLOT_W = $clog2(SLOTS);

    // one register per slot, reset to the identity mapping
    for (genvar s = 0; s < SLOTS; s++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_flat[s*ADDR_W +: ADDR_W] <= ADDR_W'(s);
            else if (wr_en && wr_slot == SLOT_W'(s))
                map_flat[s*ADDR_W +: ADDR_W] <= wr_addr;
        end
    end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int BITS   = 8,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOTS*ADDR_W-1:0]       map_live,
    input  logic [(1<<ADDR_W)-1:0]        q_valid,
    input  logic [(1<<ADDR_W)*BITS-1:0]   q_data,
    output logic [(1<<ADDR_W)-1:0]        q_pop,
    output logic                          ser_out,
    output logic                          fs_out,
    output logic [SLOTS-1:0]              slot_mask
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(BITS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS-1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS-1);

    tx_state_t               state_q, state_d;
    logic [SLOT_W-1:0]       slot_q, nxt_slot;
    logic [BIT_W-1:0]        bit_q;
    logic [BITS-1:0]         shift_q, head_byte;
    logic [SLOTS*ADDR_W-1:0] shadow_q, src_map;
    logic [ADDR_W-1:0]       sel;
    logic                    load_now, have, frame_end;

    assign frame_end = (state_q == TX_DATA) && (bit_q == LAST_BIT) && (slot_q == LAST_SLOT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_SYNC;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_SYNC: state_d = TX_DATA;
            TX_DATA: if (frame_end) state_d = TX_SYNC;
        endcase
    end

    // slot selection: the first slot reads the live table, the rest read the frame copy
    always_comb begin
        load_now  = (state_q == TX_SYNC) || ((bit_q == LAST_BIT) && (slot_q != LAST_SLOT));
        nxt_slot  = (state_q == TX_SYNC) ? '0 : slot_q + 1'b1;
        src_map   = (state_q == TX_SYNC) ? map_live : shadow_q;
        sel       = src_map[nxt_slot*ADDR_W +: ADDR_W];
        have      = q_valid[sel];
        head_byte = q_data[sel*BITS +: BITS];
        q_pop     = '0;
        if (load_now && have) q_pop[sel] = 1'b1;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            shadow_q  <= '0;
            slot_mask <= '0;
        end else begin
            if (state_q == TX_SYNC) begin
                shadow_q <= map_live;
                slot_q   <= '0;
                bit_q    <= '0;
            end else begin
                bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
                if (bit_q == LAST_BIT && slot_q != LAST_SLOT) slot_q <= slot_q + 1'b1;
            end
            if (load_now) begin
                shift_q             <= have ? head_byte : '0;
                slot_mask[nxt_slot] <= have;
            end else begin
                shift_q <= {shift_q[BITS-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        fs_out  = (state_q == TX_SYNC);
        ser_out = (state_q == TX_DATA) && shift_q[BITS-1];
    end

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fs_out |=> !fs_out); // R1
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(q_pop)); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA && bit_q == '0 && !slot_mask[slot_q]) |-> !ser_out); // R4
    AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA) |=> $stable(shadow_q)); // R7
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int BITS   = 8,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOTS*ADDR_W-1:0]  map_live,
    input  logic                     ser_in,
    input  logic                     fs_in,
    output logic [BITS-1:0]          byte_out,
    output logic [ADDR_W-1:0]        addr_out,
    output logic                     byte_valid,
    output logic                     frame_err
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(BITS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS-1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS-1);

    rx_state_t               state_q, state_d;
    logic [SLOT_W-1:0]       slot_q;
    logic [BIT_W-1:0]        bit_q;
    logic [BITS-1:0]         shift_q;
    logic [BITS-1:0]         assembled;
    logic [SLOTS*ADDR_W-1:0] shadow_q;

    assign assembled = {shift_q[BITS-2:0], ser_in};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_HUNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_HUNT: if (fs_in) state_d = RX_DATA;
            RX_DATA: if (!fs_in && bit_q == LAST_BIT && slot_q == LAST_SLOT) state_d = RX_HUNT;
        endcase
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q     <= '0;
            bit_q      <= '0;
            shift_q    <= '0;
            shadow_q   <= '0;
            byte_out   <= '0;
            addr_out   <= '0;
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
            if (fs_in) begin
                shadow_q  <= map_live;
                slot_q    <= '0;
                bit_q     <= '0;
                frame_err <= (state_q == RX_DATA);
            end else if (state_q == RX_DATA) begin
                shift_q <= assembled;
                bit_q   <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
                if (bit_q == LAST_BIT) begin
                    byte_out   <= assembled;
                    addr_out   <= shadow_q[slot_q*ADDR_W +: ADDR_W];
                    byte_valid <= 1'b1;
                    slot_q     <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) byte_valid |=> !byte_valid); // R5
    AST_ERR_AFTER_FS: assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> $past(fs_in)); // R9
    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HUNT && !fs_in) |=> !byte_valid); // R8
endmodule

// File: rtl/tdm_link.sv
module tdm_link #(
    parameter int SLOTS  = 8,
    parameter int BITS   = 8,
    parameter int ADDR_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         map_wr_en,
    input  logic [$clog2(SLOTS)-1:0]     map_wr_slot,
    input  logic [ADDR_W-1:0]            map_wr_addr,
    input  logic [(1<<ADDR_W)-1:0]       tx_q_valid,
    input  logic [(1<<ADDR_W)*BITS-1:0]  tx_q_data,
    output logic [(1<<ADDR_W)-1:0]       tx_q_pop,
    output logic                         tx_sd,
    output logic                         tx_fs,
    output logic [SLOTS-1:0]             tx_slot_mask,
    input  logic                         rx_sd,
    input  logic                         rx_fs,
    output logic [BITS-1:0]              rx_byte,
    output logic [ADDR_W-1:0]            rx_addr,
    output logic                         rx_valid,
    output logic                         rx_frame_err
);
    logic [SLOTS*ADDR_W-1:0] map_flat;

    tdm_slot_map #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(map_wr_en), .wr_slot(map_wr_slot),
        .wr_addr(map_wr_addr), .map_flat(map_flat)
    );

    tdm_tx #(.SLOTS(SLOTS), .BITS(BITS), .ADDR_W(ADDR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .map_live(map_flat), .q_valid(tx_q_valid),
        .q_data(tx_q_data), .q_pop(tx_q_pop), .ser_out(tx_sd), .fs_out(tx_fs),
        .slot_mask(tx_slot_mask)
    );

    tdm_rx #(.SLOTS(SLOTS), .BITS(BITS), .ADDR_W(ADDR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .map_live(map_flat), .ser_in(rx_sd), .fs_in(rx_fs),
        .byte_out(rx_byte), .addr_out(rx_addr), .byte_valid(rx_valid), .frame_err(rx_frame_err)
    );
endmodule

// File: tb/tdm_link_bench.sv
module tdm_link_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        map_wr_en;
    logic [2:0]  map_wr_slot, map_wr_addr;
    logic [7:0]  tx_q_valid, tx_q_pop, tx_slot_mask;
    logic [63:0] tx_q_data;
    logic        tx_sd, tx_fs, rx_sd, rx_fs, rx_valid, rx_frame_err;
    logic [7:0]  rx_byte;
    logic [2:0]  rx_addr;

    logic lb, b_fs, b_sd, chk_on;
    assign rx_fs = lb ? tx_fs : b_fs;
    assign rx_sd = lb ? tx_sd : b_sd;

    always #5 clk = ~clk;

    tdm_link u_tdm_link (
        .clk(clk), .rst_n(rst_n), .map_wr_en(map_wr_en), .map_wr_slot(map_wr_slot),
        .map_wr_addr(map_wr_addr), .tx_q_valid(tx_q_valid), .tx_q_data(tx_q_data),
        .tx_q_pop(tx_q_pop), .tx_sd(tx_sd), .tx_fs(tx_fs), .tx_slot_mask(tx_slot_mask),
        .rx_sd(rx_sd), .rx_fs(rx_fs), .rx_byte(rx_byte), .rx_addr(rx_addr),
        .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    function automatic logic [7:0] gen(input int p, input int n);
        return 8'(((p << 5) ^ (n * 7 + 3)));
    endfunction

    // bench-side peripheral queues
    int fill[8], pfill[8], used_q[8], exp_used[8];
    int req_id = 0, taken_id = 0;
    logic [7:0] pop_q;
    logic [2:0] bmap[8], bshadow[8];
    string tag = "R6";

    always_comb begin
        for (int p = 0; p < 8; p++) begin
            tx_q_valid[p]       = used_q[p] < fill[p];
            tx_q_data[p*8 +: 8] = gen(p, used_q[p]);
        end
    end

    always @(posedge clk) pop_q <= tx_q_pop;

    // monitor
    int mon_chk = 0, mon_err = 0, gap = 0, k = 0, n_cap = 0, n_err = 0, n_idle = 0, n_data = 0;
    bit seen_fs = 0;
    logic [7:0] cap_byte[256];
    logic [2:0] cap_addr[256];

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_fs) begin
                if (seen_fs) begin
                    mon_chk++;
                    if (gap != 65) begin
                        mon_err++;
                        $display("FAIL R1 R11 frame period actual=%0d expected=65", gap);
                    end
                end
                gap = 0;
                seen_fs = 1;
            end
            gap++;
            if (rx_valid) begin
                if (chk_on && k < 8) begin
                    int p;
                    bit avail;
                    logic [7:0] e;
                    p = int'(bshadow[k]);
                    avail = exp_used[p] < fill[p];
                    e = avail ? gen(p, exp_used[p]) : 8'h00;
                    if (avail) begin exp_used[p]++; n_data++; end else n_idle++;
                    mon_chk += 3;
                    if (rx_byte !== e) begin
                        mon_err++;
                        $display("FAIL R2 R3 %s slot %0d byte actual=%h expected=%h", tag, k, rx_byte, e);
                    end
                    if (rx_addr !== 3'(p)) begin
                        mon_err++;
                        $display("FAIL R5 %s slot %0d addr actual=%0d expected=%0d", tag, k, rx_addr, p);
                    end
                    if (tx_slot_mask[k] !== avail) begin
                        mon_err++;
                        $display("FAIL R4 slot %0d mask actual=%0d expected=%0d", k, tx_slot_mask[k], avail);
                    end
                    k++;
                end else if (!chk_on && n_cap < 256) begin
                    cap_byte[n_cap] = rx_byte;
                    cap_addr[n_cap] = rx_addr;
                    n_cap++;
                end
            end
            if (rx_frame_err) begin
                n_err++;
                if (chk_on) begin
                    mon_chk++;
                    mon_err++;
                    $display("FAIL R10 loopback framing error actual=1 expected=0");
                end
            end
            for (int p = 0; p < 8; p++) if (pop_q[p]) used_q[p]++;
            if (tx_fs) begin
                k = 0;
                for (int s = 0; s < 8; s++) bshadow[s] = bmap[s];
                if (req_id != taken_id) begin
                    for (int p = 0; p < 8; p++) fill[p] = pfill[p];
                    taken_id = req_id;
                end
            end
        end
    end

    int chks = 0, errs = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_fs();
        do @(negedge clk); while (!tx_fs);
    endtask

    task automatic write_map(input int slot, input int addr);
        map_wr_en   = 1'b1;
        map_wr_slot = 3'(slot);
        map_wr_addr = 3'(addr);
        bmap[slot]  = 3'(addr);
        @(negedge clk);
        map_wr_en = 1'b0;
    endtask

    task automatic rx_bit(input bit fs, input bit sd);
        b_fs = fs;
        b_sd = sd;
        @(negedge clk);
    endtask

    task automatic rx_send(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) rx_bit(1'b0, b[i]);
    endtask

    function automatic logic [7:0] pat(input int s);
        return 8'(s * 17 + 5);
    endfunction

    int base_c, base_e;

    initial begin
        rst_n = 1'b0; lb = 1'b1; chk_on = 1'b1; b_fs = 1'b0; b_sd = 1'b0;
        map_wr_en = 1'b0; map_wr_slot = '0; map_wr_addr = '0;
        for (int p = 0; p < 8; p++) begin
            fill[p] = 0; used_q[p] = 0; exp_used[p] = 0; pfill[p] = 4;
            bmap[p] = 3'(p); bshadow[p] = 3'(p);
        end
        req_id = 1;
        repeat (3) @(negedge clk);
        check(tx_fs === 1'b1, "R1 reset tx_fs", int'(tx_fs), 1);
        check(tx_sd === 1'b0, "R1 reset tx_sd", int'(tx_sd), 0);
        check(rx_valid === 1'b0, "R5 reset rx_valid", int'(rx_valid), 0);
        check(rx_frame_err === 1'b0, "R9 reset rx_frame_err", int'(rx_frame_err), 0);
        check(tx_slot_mask === 8'h00, "R4 reset mask", int'(tx_slot_mask), 0);
        rst_n = 1'b1;

        // identity map, four bytes per peripheral
        tag = "R6";
        repeat (5) wait_fs();

        // uneven bandwidth, written mid-frame
        wait_fs();
        tag = "R3 R7";
        repeat (3) @(negedge clk);
        write_map(0, 0); write_map(1, 0); write_map(2, 0); write_map(3, 0);
        write_map(4, 1); write_map(5, 1); write_map(6, 2); write_map(7, 3);
        pfill[0] = fill[0] + 10; pfill[1] = fill[1] + 6; pfill[2] = fill[2] + 1; pfill[3] = fill[3] + 3;
        for (int p = 4; p < 8; p++) pfill[p] = fill[p];
        req_id++;
        repeat (5) wait_fs();

        // every slot to one peripheral
        repeat (3) @(negedge clk);
        for (int s = 0; s < 8; s++) write_map(s, 5);
        for (int p = 0; p < 8; p++) pfill[p] = fill[p];
        pfill[5] = fill[5] + 12;
        req_id++;
        repeat (4) wait_fs();

        // reversed map
        repeat (3) @(negedge clk);
        for (int s = 0; s < 8; s++) write_map(s, 7 - s);
        for (int p = 0; p < 8; p++) pfill[p] = fill[p] + 8;
        req_id++;
        repeat (3) wait_fs();

        check(n_idle > 0, "R4 idle slots seen", n_idle, 1);
        check(n_data > 0, "R3 data slots seen", n_data, 1);

        // receive path driven directly
        wait_fs();
        lb = 1'b0;
        chk_on = 1'b0;
        repeat (2) @(negedge clk);

        base_c = n_cap; base_e = n_err;
        for (int i = 0; i < 16; i++) rx_bit(1'b0, 1'b1);
        repeat (2) @(negedge clk);
        check(n_cap == base_c, "R8 bytes while hunting", n_cap - base_c, 0);
        check(n_err == base_e, "R8 errors while hunting", n_err - base_e, 0);

        // early sync after three bytes
        base_c = n_cap; base_e = n_err;
        rx_bit(1'b1, 1'b0);
        rx_send(8'hA5); rx_send(8'h3C); rx_send(8'h81);
        rx_bit(1'b1, 1'b0);
        for (int s = 0; s < 8; s++) rx_send(pat(s));
        for (int i = 0; i < 4; i++) rx_bit(1'b0, 1'b0);
        check(n_err - base_e == 1, "R9 framing error count", n_err - base_e, 1);
        check(n_cap - base_c == 11, "R9 bytes captured", n_cap - base_c, 11);
        check(cap_byte[base_c] == 8'hA5, "R2 byte 0", int'(cap_byte[base_c]), 'hA5);
        check(cap_byte[base_c+1] == 8'h3C, "R2 byte 1", int'(cap_byte[base_c+1]), 'h3C);
        check(cap_byte[base_c+2] == 8'h81, "R2 byte 2", int'(cap_byte[base_c+2]), 'h81);
        for (int s = 0; s < 3; s++)
            check(cap_addr[base_c+s] == bmap[s], "R5 addr before resync", int'(cap_addr[base_c+s]), int'(bmap[s]));
        for (int s = 0; s < 8; s++) begin
            check(cap_byte[base_c+3+s] == pat(s), "R9 byte after resync", int'(cap_byte[base_c+3+s]), int'(pat(s)));
            check(cap_addr[base_c+3+s] == bmap[s], "R9 addr after resync", int'(cap_addr[base_c+3+s]), int'(bmap[s]));
        end

        // back-to-back complete frames, map change inside the first
        base_c = n_cap; base_e = n_err;
        rx_bit(1'b1, 1'b0);
        rx_send(pat(0));
        map_wr_en = 1'b1; map_wr_slot = 3'd2; map_wr_addr = 3'd6;
        rx_bit(1'b0, pat(1)[7]);
        map_wr_en = 1'b0;
        for (int i = 6; i >= 0; i--) rx_bit(1'b0, pat(1)[i]);
        for (int s = 2; s < 8; s++) rx_send(pat(s));
        rx_bit(1'b1, 1'b0);
        for (int s = 0; s < 8; s++) rx_send(pat(s + 8));
        for (int i = 0; i < 4; i++) rx_bit(1'b0, 1'b0);
        check(n_err == base_e, "R10 no error after full frame", n_err - base_e, 0);
        check(n_cap - base_c == 16, "R10 bytes captured", n_cap - base_c, 16);
        check(cap_addr[base_c+2] == bmap[2], "R7 rx old map mid-frame", int'(cap_addr[base_c+2]), int'(bmap[2]));
        check(cap_addr[base_c+10] == 3'd6, "R7 rx new map next frame", int'(cap_addr[base_c+10]), 6);
        check(cap_byte[base_c+15] == pat(15), "R2 last byte", int'(cap_byte[base_c+15]), int'(pat(15)));

        repeat (70) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs + mon_err, chks + mon_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs + mon_err + 1, chks + mon_chk + 1);
        $finish;
    end
endmodule